// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Write-Protect Cancel

This block is a 4096-byte serial memory that sits on a two-wire bus as a slave. It runs from a fast system clock and samples the bus clock (SCL) and data (SDA) lines with it. SDA is open-drain: the block drives it low through `sda_oe` and reads the resolved line through `sda_i`. A transfer opens with a START and is closed by a STOP. The first byte carries a 7-bit device identity and a direction bit. For writes, two address bytes come next, and then data bytes go into a page buffer. A STOP after the data starts an internally timed write cycle. That cycle copies the buffered bytes into the array and lasts `TWR_CYCLES` system clocks. For reads, bytes stream out from the current address, and the address rises after each byte that the master acknowledges.

A write-protect input `wp_i` guards each write. It becomes active at the SCL rising edge that samples the last bit of the first data byte, and stays active until the write cycle ends. If it is seen high before the STOP, the write is dropped and the array keeps its old contents. If it is seen high during the write cycle, the cycle stops at once and the page being written is left undefined.

The protocol controller has nine states:
- IDLE waits for a START.
- DEV, AHI, ALO and WDATA each shift in one byte.
- SACK drives the slave acknowledge.
- RDATA shifts a byte out.
- MACK samples the master acknowledge.
- WAIT ignores the bus until the next START or STOP.

The transitions are as follows:
- A START moves any state to DEV, and a STOP moves any state to IDLE.
- At the end of an 8-bit byte, a receive state moves to SACK and records a return state: DEV returns to AHI or RDATA, AHI to ALO, ALO to WDATA, and WDATA to WDATA. A device byte that does not match moves to WAIT instead.
- The SCL fall that ends the acknowledge moves SACK to its return state.
- The eighth bit moves RDATA to MACK.
- MACK goes back to RDATA on a master ACK, or to WAIT on a NACK.

Top module: `eep_i2c_slave`

## Requirements
- R1: While reset is asserted, and after it is released with no bus traffic, `sda_oe` is 0 and SDA stays released.
- R2: A device byte whose upper 7 bits equal 7'b1010000 is acknowledged: SDA is low during the ninth SCL high phase. Any other identity gets no acknowledge, and the rest of that transfer is ignored.
- R3: In a write, the device byte (bit 0 = 0) is followed by the high address byte, the low address byte and the data bytes, and each of these bytes is acknowledged. After the STOP and `TWR_CYCLES` clocks, a read returns the written bytes.
- R4: Write data lands in a 32-byte page. The page is selected by address bits [11:5], and the low 5 bits wrap within the page, so a later byte to the same slot replaces an earlier one.
- R5: A read starts at the loaded address and advances by one after every master ACK. The address crosses page boundaries and wraps from 4095 to 0.
- R6: While a write cycle is running, the block does not acknowledge its own device byte. It acknowledges again once the cycle has ended.
- R7: If `wp_i` is high at any point from the SCL rise that samples bit 0 of the first data byte until the STOP, no write cycle starts, the array is unchanged, and the device byte is acknowledged right after the STOP.
- R8: `wp_i` being high before that window opens, for example during the address bytes, does not prevent the write.
- R9: `wp_i` high during a write cycle ends the cycle in the next clock, so the device is acknowledged at once. Bytes outside the page being written are unaffected.
- R10: After a master NACK on a read byte, SDA is released before the master issues the STOP, and the block then accepts a new transfer.
- R11: A repeated START after write data, with no STOP, discards the buffered data: the array is unchanged and no write cycle starts.
- R12: Only the low 4 bits of the high address byte are used; the upper 4 bits are ignored.
- R13: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Resolved bus data line |
| wp_i | input | 1 | Write protect; high cancels or aborts a write |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |

## Verification
The bench builds the block with the default 12-bit address and 32-byte page, and shortens `TWR_CYCLES` to 400. With this value, a probe right after a STOP falls inside the write cycle, and a wait of just over 400 clocks lets the next transfer start after it. The short cycle also leaves room for a mid-cycle write-protect pulse and for several random page writes of up to 36 bytes within the run. The full address width brings the wrap from 4095 to 0 within reach, along with page wrap and the ignored upper bits of the high address byte.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_SACK,
        ST_RDATA,
        ST_MACK,
        ST_WAIT
    } state_t;

endpackage

// File: rtl/eep_bus_sampler.sv
module eep_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_m, scl_s, scl_d;
    logic sda_m, sda_s, sda_d;

    // two-stage synchronisers plus one delayed copy for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            scl_s <= 1'b1;
            scl_d <= 1'b1;
            sda_m <= 1'b1;
            sda_s <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_m <= scl_i;
            scl_s <= scl_m;
            scl_d <= scl_s;
            sda_m <= sda_i;
            sda_s <= sda_m;
            sda_d <= sda_s;
        end
    end

    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eep_page_buffer.sv
module eep_page_buffer #(
    parameter int PAGE_BYTES = 32,
    parameter int DW         = 8,
    localparam int PW        = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    logic [DW-1:0] slot_data  [PAGE_BYTES];
    logic          slot_valid [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic          v_q;
        logic [DW-1:0] d_q;
        logic          hit;

        assign hit = we && (waddr == PW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (hit) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) begin
                d_q <= wdata;
            end
        end

        assign slot_data[g]  = d_q;
        assign slot_valid[g] = v_q;
    end

    assign rdata  = slot_data[raddr];
    assign rvalid = slot_valid[raddr];

endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
    parameter int TWR_CYCLES = 2000,
    parameter int CW         = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          abort,
    output logic          busy,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (abort || cnt == CW'(TWR_CYCLES - 1)) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (go) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
    parameter int ADDR_W = 12,
    parameter int DW     = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          PAGE_BYTES = 32,
    parameter int          TWR_CYCLES = 2000,
    parameter logic [6:0]  DEV_ID     = 7'b1010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);

    localparam int PW   = $clog2(PAGE_BYTES);
    localparam int CW   = $clog2(TWR_CYCLES + 1);
    localparam int HI_W = ADDR_W - 8;

    // bus events
    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    // controller state
    state_t            state, ret_state;
    logic [3:0]        bit_cnt;
    logic [7:0]        sreg;
    logic [7:0]        tx;
    logic [ADDR_W-1:0] addr;
    logic [HI_W-1:0]   addr_hi;
    logic              m_ack;
    logic              have_data;
    logic              armed;
    logic              cancel;

    // datapath links
    logic              arm_now;
    logic              byte_done;
    logic              buf_we, buf_clr, buf_rvalid;
    logic [7:0]        buf_rdata;
    logic              wr_go, wr_busy;
    logic [CW-1:0]     wr_cnt;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, rd_sel;
    logic [7:0]        rd_data;

    eep_bus_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_page_buffer #(
        .PAGE_BYTES (PAGE_BYTES),
        .DW         (8)
    ) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (buf_clr),
        .we     (buf_we),
        .waddr  (addr[PW-1:0]),
        .wdata  (sreg),
        .raddr  (wr_cnt[PW-1:0]),
        .rdata  (buf_rdata),
        .rvalid (buf_rvalid)
    );

    eep_write_timer #(
        .TWR_CYCLES (TWR_CYCLES),
        .CW         (CW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (wr_go),
        .abort (wp_i),
        .busy  (wr_busy),
        .cnt   (wr_cnt)
    );

    eep_mem_array #(
        .ADDR_W (ADDR_W),
        .DW     (8)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (buf_rdata),
        .raddr (rd_sel),
        .rdata (rd_data)
    );

    // cancel window opens on the rise that samples D0 of the first data byte
    assign arm_now   = (state == ST_WDATA) && scl_rise && (bit_cnt == 4'd7) && !have_data;
    assign byte_done = scl_fall && (bit_cnt == 4'd8);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ret_state <= ST_IDLE;
            bit_cnt   <= '0;
            sreg      <= '0;
            tx        <= 8'hFF;
            addr      <= '0;
            addr_hi   <= '0;
            m_ack     <= 1'b0;
            have_data <= 1'b0;
            armed     <= 1'b0;
            cancel    <= 1'b0;
        end else if (start_det) begin
            state     <= ST_DEV;
            bit_cnt   <= '0;
            have_data <= 1'b0;
            armed     <= 1'b0;
            cancel    <= 1'b0;
        end else if (stop_det) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            have_data <= 1'b0;
            armed     <= 1'b0;
            cancel    <= 1'b0;
        end else begin
            if (wp_i && (armed || arm_now)) begin
                cancel <= 1'b1;
            end
            if (arm_now) begin
                armed <= 1'b1;
            end
            unique case (state)
                ST_IDLE, ST_WAIT: begin
                end
                ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        sreg    <= {sreg[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        state   <= ST_SACK;
                        if (state == ST_DEV) begin
                            if (sreg[7:1] == DEV_ID && !wr_busy) begin
                                ret_state <= sreg[0] ? ST_RDATA : ST_AHI;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end else if (state == ST_AHI) begin
                            addr_hi   <= sreg[HI_W-1:0];
                            ret_state <= ST_ALO;
                        end else if (state == ST_ALO) begin
                            addr      <= {addr_hi, sreg};
                            ret_state <= ST_WDATA;
                        end else begin
                            addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
                            have_data    <= 1'b1;
                            ret_state    <= ST_WDATA;
                        end
                    end
                end
                ST_SACK: begin
                    if (scl_fall) begin
                        state <= ret_state;
                        if (ret_state == ST_RDATA) begin
                            tx <= rd_data;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            state   <= ST_MACK;
                            bit_cnt <= '0;
                        end else begin
                            tx <= {tx[6:0], 1'b1};
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (m_ack) begin
                            addr  <= addr + 1'b1;
                            tx    <= rd_data;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs and strobes
    always_comb begin
        sda_oe    = (state == ST_SACK) || ((state == ST_RDATA) && !tx[7]);
        buf_we    = (state == ST_WDATA) && byte_done;
        buf_clr   = start_det && !wr_busy;
        wr_go     = stop_det && (state == ST_WDATA) && have_data && !cancel && !wp_i;
        mem_we    = wr_busy && !wp_i && (wr_cnt < CW'(PAGE_BYTES)) && buf_rvalid;
        mem_waddr = {addr[ADDR_W-1:PW], wr_cnt[PW-1:0]};
        rd_sel    = (state == ST_MACK) ? addr + 1'b1 : addr;
    end

endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk
    import eep_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   scl_i,
    input logic   wp_i,
    input logic   sda_oe,
    input logic   busy,
    input logic   stop_det,
    input logic   cancel,
    input state_t state,
    input state_t ret_state
);

    assert_reset_release_R1: assert property (@(posedge clk)
        !rst_n |-> !sda_oe);

    assert_drive_on_low_scl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    assert_busy_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state == ST_SACK) |-> (ret_state != ST_AHI && ret_state != ST_RDATA));

    assert_cancel_no_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && cancel) |=> !busy);

    assert_abort_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wp_i) |=> !busy);

endmodule

bind eep_i2c_slave eep_i2c_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .wp_i      (wp_i),
    .sda_oe    (sda_oe),
    .busy      (wr_busy),
    .stop_det  (stop_det),
    .cancel    (cancel),
    .state     (state),
    .ret_state (ret_state)
);

// File: tb/eep_i2c_slave_bench.sv
module eep_i2c_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;
    localparam int TWR        = 400;
    localparam logic [6:0] DEV = 7'b1010000;

    logic clk = 1'b0;
    logic rst_n, scl, m_low, wp;
    wire  sda_oe;
    wire  sda_bus = ~(sda_oe | m_low);

    always #(CLK_PERIOD / 2) clk = ~clk;

    eep_i2c_slave #(.TWR_CYCLES(TWR)) u_eep_i2c_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    logic [7:0] mdl   [0:4095];
    bit         known [0:4095];
    logic [7:0] wbuf  [0:63];
    int n_chk = 0;
    int n_err = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        m_low = 1'b0; qwait();
        scl = 1'b1;   qwait();
        m_low = 1'b1; qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic bstop();
        m_low = 1'b1; qwait();
        scl = 1'b1;   qwait();
        m_low = 1'b0; qwait();
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; qwait();
        scl = 1'b1; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        logic late;
        m_low = 1'b0; qwait();
        scl = 1'b1;
        repeat (2) @(negedge clk);
        b = sda_bus;
        repeat (Q - 3) @(negedge clk);
        late = sda_bus;
        check("R13", int'(late), int'(b));
        @(negedge clk);
        scl = 1'b0; qwait();
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic probe(input logic [7:0] dbyte, input int exp_ack, input string tag);
        logic a;
        bstart();
        put_byte(dbyte, a);
        bstop();
        check(tag, int'(a), exp_ack);
    endtask

    // mode: 0 normal, 1 cancel before STOP, 2 wp high during address,
    //       3 abort during write cycle, 4 repeated START instead of STOP
    task automatic do_write(input int a, input int n, input int mode, input logic [3:0] junk,
                            input bit early_probe, input string tag);
        logic ack;
        int   base;
        bstart();
        if (mode == 2) wp = 1'b1;
        put_byte({DEV, 1'b0}, ack);            check("R2", int'(ack), 1);
        put_byte({junk, 4'(a >> 8)}, ack);     check(tag, int'(ack), 1);
        put_byte(8'(a), ack);                  check(tag, int'(ack), 1);
        if (mode == 2) wp = 1'b0;
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], ack);
            check(tag, int'(ack), 1);
        end
        if (mode == 1) wp = 1'b1;
        if (mode == 4) begin
            bstart();
        end
        bstop();
        if (mode == 1) begin
            qwait();
            wp = 1'b0;
        end
        base = a & 4064;
        if (mode == 0 || mode == 2 || mode == 3) begin
            for (int i = 0; i < n; i++) begin
                mdl[base + ((a + i) & 31)]   = wbuf[i];
                known[base + ((a + i) & 31)] = (mode != 3);
            end
        end
        if (mode == 3) begin
            repeat (TWR / 2) @(negedge clk);
            wp = 1'b1;
            repeat (3) @(negedge clk);
            wp = 1'b0;
        end
        if (mode == 0 || mode == 2) begin
            if (early_probe) begin
                probe({DEV, 1'b0}, 0, "R6");
                repeat (TWR + 20) @(negedge clk);
                probe({DEV, 1'b0}, 1, "R6");
            end else begin
                repeat (TWR + 20) @(negedge clk);
            end
        end else begin
            probe({DEV, 1'b0}, 1, tag);
        end
    endtask

    task automatic do_read(input int a, input int n, input string tag);
        logic       ack;
        logic [7:0] d;
        int         x;
        bstart();
        put_byte({DEV, 1'b0}, ack);     check("R2", int'(ack), 1);
        put_byte({4'h0, 4'(a >> 8)}, ack);
        put_byte(8'(a), ack);
        bstart();
        put_byte({DEV, 1'b1}, ack);     check("R2", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            get_byte(i < n - 1, d);
            x = (a + i) & 4095;
            if (known[x]) check(tag, int'(d), int'(mdl[x]));
        end
        check("R10", int'(sda_bus), 1);
        bstop();
    endtask

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) wbuf[i] = 8'((seed * 37 + i * 11 + 5) ^ (i << 3));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int a, n, s;
        s = $urandom(32'h5EED_1234);
        rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; wp = 1'b0;
        repeat (5) @(negedge clk);
        check("R1", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1", int'(sda_bus), 1);

        // R2: identity decode
        probe({7'h51, 1'b0}, 0, "R2");
        probe({7'h28, 1'b1}, 0, "R2");
        probe({DEV, 1'b0}, 1, "R2");

        // R3: plain write and readback
        fill(4, 1);
        do_write(12'h123, 4, 0, 4'h0, 1'b0, "R3");
        do_read(12'h123, 4, "R3");

        // R6: busy during write cycle
        fill(3, 2);
        do_write(12'h200, 3, 0, 4'h0, 1'b1, "R6");
        do_read(12'h200, 3, "R6");

        // R4: page wrap with overwrite
        fill(36, 3);
        do_write(12'h03E, 36, 0, 4'h0, 1'b0, "R4");
        do_read(12'h020, 32, "R4");

        // R5: read wraps from 4095 to 0
        fill(2, 4);
        do_write(12'hFFE, 2, 0, 4'h0, 1'b0, "R5");
        fill(2, 5);
        do_write(12'h000, 2, 0, 4'h0, 1'b0, "R5");
        do_read(12'hFFE, 4, "R5");
        do_read(12'h01E, 4, "R5");

        // R12: upper nibble of high address byte ignored
        fill(3, 6);
        do_write(12'h456, 3, 0, 4'hB, 1'b0, "R12");
        do_read(12'h456, 3, "R12");

        // R7: cancel before STOP keeps old contents
        fill(4, 7);
        do_write(12'h300, 4, 0, 4'h0, 1'b0, "R7");
        fill(4, 8);
        do_write(12'h300, 4, 1, 4'h0, 1'b0, "R7");
        do_read(12'h300, 4, "R7");

        // R8: wp high before the window
        fill(4, 9);
        do_write(12'h340, 4, 2, 4'h0, 1'b0, "R8");
        do_read(12'h340, 4, "R8");

        // R11: repeated START discards buffered data
        fill(4, 10);
        do_write(12'h300, 4, 4, 4'h0, 1'b0, "R11");
        do_read(12'h300, 4, "R11");

        // R9: abort during write cycle
        fill(2, 11);
        do_write(12'h3A0, 2, 0, 4'h0, 1'b0, "R9");
        fill(5, 12);
        do_write(12'h380, 5, 3, 4'h0, 1'b0, "R9");
        do_read(12'h3A0, 2, "R9");

        // R10: NACK ends read, then a new transfer is accepted
        do_read(12'h123, 1, "R10");
        probe({DEV, 1'b0}, 1, "R10");

        // random page writes and readback
        for (int it = 0; it < 8; it++) begin
            a = int'($urandom % 4096);
            n = 1 + int'($urandom % 36);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(a, n, 0, 4'h0, 1'b0, "R3");
            do_read(a & 4064, 34, "R4");
        end

        finish_run();
    end

endmodule